// File: doc/BRIEF.md
# Serial Duty-Word Loader with Switch Readback

This block is a serial slave that lets a host processor load the duty words of a bank of PWM channels over one long frame. In the same transfer it returns the states of a group of local switch inputs. The bits from the host shift into a chain register that is one duty word wide per channel. When the host ends the frame, a holding register takes a copy of the whole chain. The holding register then drives the downstream PWM bank as parallel duty words, and it stays still while the next frame is being shifted in.

All serial pins are oversampled in the system clock domain. Two flops synchronise them and a further register detects their edges, so every register in the block runs on one clock. A frame commits only when its bit count equals the chain length exactly. If the host sends too few bits or too many, the frame is dropped. A build parameter can remove the holding register, for designs that cannot spare the flops. In that build the duty outputs follow the chain directly, and they glitch while bits are shifting.

Top module: `spi_duty_chain`

## Requirements
- R1: After reset, every duty output bit is 0, `miso_o` is 0 and `latch_pulse_o` is 0.
- R2: A frame of exactly NUM_CH*DUTY_W bits, sent most significant bit first, becomes the duty output. The first DUTY_W bits go to the highest channel, in bits [NUM_CH*DUTY_W-1 -: DUTY_W]. Channel k sits in bits [k*DUTY_W +: DUTY_W].
- R3: A frame with fewer bits than the chain length leaves the latched duty outputs unchanged and produces no latch pulse.
- R4: A frame with more bits than the chain length leaves the latched duty outputs unchanged and produces no latch pulse.
- R5: With the holding register built in, the duty outputs keep their previous value for the whole time a frame is shifting.
- R6: The switch states are sampled when chip-select goes low. They are returned on `miso_o` most significant switch first, one bit per SCK period, and each bit changes after an SCK falling edge. Every bit after the NUM_SW switch bits reads 0.
- R7: SCK edges while chip-select is high shift nothing, and `miso_o` stays 0 while chip-select is high.
- R8: With the holding register removed (LATCH_EN=0), the duty outputs follow the chain after every bit, including the bits of frames that are later dropped.
- R9: Each committed frame raises `latch_pulse_o` for exactly one clock, in the same cycle that the new duty words appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the host, idle low |
| cs_n_i | input | 1 | Chip-select from the host, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host (switch states) |
| sw_i | input | NUM_SW | Asynchronous switch inputs |
| duty_o | output | NUM_CH*DUTY_W | Parallel duty words, channel k at [k*DUTY_W +: DUTY_W] |
| latch_pulse_o | output | 1 | One-clock strobe when new duty words take effect |

## Verification
The bench builds two copies on the same serial pins, each with 4 channels of 6 bits and 4 switches. That gives a 24-bit chain, so every frame stays short and a frame of 23 or 25 bits is cheap to send. One copy keeps the holding register and the other drops it. Watching both at once shows the mid-frame stability of the latched build next to the bit-by-bit tracking of the pass-through build, including after dropped frames. The small switch count leaves 20 trailing bits in each frame in which to see MISO read zero.

// File: rtl/spi_duty_pkg.sv
package spi_duty_pkg;

    localparam int DEF_CHANNELS = 45;
    localparam int DEF_DUTY_W   = 10;
    localparam int DEF_SWITCHES = 8;

    // edge events of one oversampled pin
    typedef struct packed {
        logic rise;
        logic fall;
    } pin_evt_t;

    function automatic int chain_len(input int channels, input int width);
        return channels * width;
    endfunction

endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= INIT;
            stage2_q <= INIT;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/sdr_edge.sv
module sdr_edge
    import spi_duty_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    output pin_evt_t evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign evt.rise = lvl & ~prev_q;
    assign evt.fall = ~lvl & prev_q;
endmodule

// File: rtl/sdr_shift_core.sv
module sdr_shift_core
    import spi_duty_pkg::*;
#(
    parameter int CHAIN_W = 450,
    parameter int NSW     = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_act,
    input  pin_evt_t           cs_evt,
    input  pin_evt_t           sck_evt,
    input  logic               mosi_s,
    input  logic [NSW-1:0]     sw_s,
    output logic [CHAIN_W-1:0] chain_o,
    output logic               frame_done_o,
    output logic               miso_o
);
    localparam int                 CNT_W    = $clog2(CHAIN_W + 2);
    localparam logic [CNT_W-1:0]   CNT_FULL = CNT_W'(CHAIN_W);
    localparam logic [CNT_W-1:0]   CNT_SAT  = CNT_W'(CHAIN_W + 1);

    logic [CHAIN_W-1:0] chain_q;
    logic [CNT_W-1:0]   bit_cnt;
    logic [NSW-1:0]     tx_sr;
    logic               done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cs_evt.rise) begin
                bit_cnt <= '0;
                tx_sr   <= sw_s;
            end else if (cs_act && sck_evt.rise) begin
                chain_q <= {chain_q[CHAIN_W-2:0], mosi_s};
                if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            end else if (cs_act && sck_evt.fall) begin
                tx_sr <= {tx_sr[NSW-2:0], 1'b0};
            end
            if (cs_evt.fall && bit_cnt == CNT_FULL) done_q <= 1'b1;
        end
    end

    assign chain_o      = chain_q;
    assign frame_done_o = done_q;
    assign miso_o       = cs_act & tx_sr[NSW-1];

    // R7: no shifting while deselected
    a_r7_idle_no_shift: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> $stable(chain_q));
    // R6: return data only moves on SCK fall or frame start
    a_r6_tx_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!sck_evt.fall && !cs_evt.rise) |=> $stable(tx_sr));
    // R4: bit counter never passes its saturation value
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_SAT);
endmodule

// File: rtl/sdr_hold.sv
module sdr_hold #(
    parameter int CHAIN_W  = 450,
    parameter bit LATCH_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [CHAIN_W-1:0] chain_i,
    output logic [CHAIN_W-1:0] duty_o
);
    generate
        if (LATCH_EN) begin : g_latched
            logic [CHAIN_W-1:0] hold_q;
            always_ff @(posedge clk) begin
                if (rst)       hold_q <= '0;
                else if (load) hold_q <= chain_i;
            end
            assign duty_o = hold_q;

            // R5: holding register changes only on a commit
            a_r5_hold_only_on_load: assert property (@(posedge clk) disable iff (rst)
                !load |=> $stable(hold_q));
        end else begin : g_through
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst, load};
            assign duty_o     = chain_i;
        end
    endgenerate
endmodule

// File: rtl/spi_duty_chain.sv
module spi_duty_chain
    import spi_duty_pkg::*;
#(
    parameter int NUM_CH   = DEF_CHANNELS,
    parameter int DUTY_W   = DEF_DUTY_W,
    parameter int NUM_SW   = DEF_SWITCHES,
    parameter bit LATCH_EN = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sck_i,
    input  logic                       cs_n_i,
    input  logic                       mosi_i,
    output logic                       miso_o,
    input  logic [NUM_SW-1:0]          sw_i,
    output logic [NUM_CH*DUTY_W-1:0]   duty_o,
    output logic                       latch_pulse_o
);
    localparam int CHAIN_W = chain_len(NUM_CH, DUTY_W);

    logic [2:0]        pins_s;   // {cs_n, sck, mosi}
    logic [NUM_SW-1:0] sw_s;
    logic              cs_act;
    pin_evt_t          cs_evt;
    pin_evt_t          sck_evt;
    logic [CHAIN_W-1:0] chain;
    logic              frame_done;
    logic              pulse_q;

    sdr_sync #(.W(3), .INIT(3'b100)) u_pin_sync (
        .clk(clk), .rst(rst), .d({cs_n_i, sck_i, mosi_i}), .q(pins_s)
    );

    sdr_sync #(.W(NUM_SW), .INIT('0)) u_sw_sync (
        .clk(clk), .rst(rst), .d(sw_i), .q(sw_s)
    );

    assign cs_act = ~pins_s[2];

    sdr_edge u_cs_edge  (.clk(clk), .rst(rst), .lvl(cs_act),    .evt(cs_evt));
    sdr_edge u_sck_edge (.clk(clk), .rst(rst), .lvl(pins_s[1]), .evt(sck_evt));

    sdr_shift_core #(.CHAIN_W(CHAIN_W), .NSW(NUM_SW)) u_core (
        .clk(clk), .rst(rst), .cs_act(cs_act), .cs_evt(cs_evt),
        .sck_evt(sck_evt), .mosi_s(pins_s[0]), .sw_s(sw_s),
        .chain_o(chain), .frame_done_o(frame_done), .miso_o(miso_o)
    );

    sdr_hold #(.CHAIN_W(CHAIN_W), .LATCH_EN(LATCH_EN)) u_hold (
        .clk(clk), .rst(rst), .load(frame_done), .chain_i(chain), .duty_o(duty_o)
    );

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= frame_done;
    end
    assign latch_pulse_o = pulse_q;

    // R9: strobe lasts one clock
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
        latch_pulse_o |=> !latch_pulse_o);
endmodule

// File: tb/spi_duty_chain_tb.sv
`timescale 1ns/1ps
module spi_duty_chain_tb;
    localparam int CH = 4, W = 6, SW = 4, N = CH * W, HALF = 6;
    localparam logic [N-1:0] MASK = '1;
    // {switches, frame}
    localparam logic [SW+N-1:0] VEC [4] = '{
        28'h5_123456, 28'hA_FFFFFF, 28'h3_000001, 28'hC_8A0C35
    };

    logic clk = 0, rst = 1, sck = 0, cs_n = 1, mosi = 0;
    logic [SW-1:0] sw = '0;
    logic miso_l, miso_t, pulse_l, pulse_t;
    logic [N-1:0] duty_l, duty_t;
    int errors = 0, checks = 0, pulse_cnt = 0;
    logic [N-1:0] held = '0;
    logic [63:0] rx;

    always #4 clk = ~clk;

    spi_duty_chain #(.NUM_CH(CH), .DUTY_W(W), .NUM_SW(SW), .LATCH_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
        .miso_o(miso_l), .sw_i(sw), .duty_o(duty_l), .latch_pulse_o(pulse_l));
    spi_duty_chain #(.NUM_CH(CH), .DUTY_W(W), .NUM_SW(SW), .LATCH_EN(1'b0)) u_dut_thru (
        .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
        .miso_o(miso_t), .sw_i(sw), .duty_o(duty_t), .latch_pulse_o(pulse_t));

    always @(posedge clk) if (!rst && pulse_l) pulse_cnt++;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [63:0] data, input int nbits);
        rx = '0;
        cs_n = 0;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = data[i];
            wait_clk(HALF);
            rx = {rx[62:0], miso_l};
            sck = 1;
            wait_clk(HALF);
            if (i == nbits / 2) check("R5 mid-frame hold", 64'(duty_l), 64'(held));
            sck = 0;
        end
        wait_clk(HALF);
        cs_n = 1;
        wait_clk(10);
    endtask

    initial begin
        int pc;
        logic [N-1:0] thru;
        wait_clk(4);
        check("R1 duty latched", 64'(duty_l), 64'd0);
        check("R1 duty thru", 64'(duty_t), 64'd0);
        check("R1 miso", 64'(miso_l), 64'd0);
        check("R1 pulse", 64'(pulse_l), 64'd0);
        rst = 0;
        wait_clk(4);

        // table of vectors
        for (int v = 0; v < 4; v++) begin
            logic [N-1:0] f;
            f  = VEC[v][N-1:0];
            sw = VEC[v][SW+N-1:N];
            pc = pulse_cnt;
            xfer(64'(f), N);
            check("R2 duty word", 64'(duty_l), 64'(f));
            check("R2 top channel gets first bits", 64'(duty_l[N-1 -: W]), 64'(f[N-1 -: W]));
            check("R6 switch readback", rx, 64'({sw, {(N-SW){1'b0}}}));
            check("R9 one pulse per frame", 64'(pulse_cnt - pc), 64'd1);
            check("R8 thru follows", 64'(duty_t), 64'(f));
            held = f;
        end

        // short frame
        pc = pulse_cnt;
        xfer(64'h2AB, 10);
        check("R3 short frame ignored", 64'(duty_l), 64'(held));
        check("R3 no pulse", 64'(pulse_cnt - pc), 64'd0);
        thru = (held << 10) | N'(10'h2AB);
        check("R8 thru after short", 64'(duty_t), 64'(thru));

        // frame one bit short
        xfer(64'h7654321, N - 1);
        check("R3 N-1 ignored", 64'(duty_l), 64'(held));

        // long frame
        pc = pulse_cnt;
        xfer(64'h1F0F0F0, N + 1);
        check("R4 long frame ignored", 64'(duty_l), 64'(held));
        check("R4 no pulse", 64'(pulse_cnt - pc), 64'd0);
        check("R8 thru after long", 64'(duty_t), 64'(64'h1F0F0F0 & 64'(MASK)));
        thru = duty_t;

        // SCK while deselected
        mosi = 1;
        for (int k = 0; k < 5; k++) begin
            sck = 1; wait_clk(HALF);
            check("R7 miso idle", 64'(miso_l), 64'd0);
            sck = 0; wait_clk(HALF);
        end
        check("R7 no shift when idle", 64'(duty_t), 64'(thru));
        check("R7 latched unchanged", 64'(duty_l), 64'(held));

        // recovery frame
        sw = 4'b1001;
        pc = pulse_cnt;
        xfer(64'h3C3C3C, N);
        check("R2 commit after dropped frames", 64'(duty_l), 64'h3C3C3C);
        check("R9 pulse after recovery", 64'(pulse_cnt - pc), 64'd1);
        check("R6 readback recovery", rx, 64'({4'b1001, {(N-SW){1'b0}}}));
        check("R2 channel 0", 64'(duty_l[0 +: W]), 64'(6'h3C));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule